// File: doc/BRIEF.md
# Dual-Chamber Pacing Timing Controller

This block is the timing core of a dual-chamber pacemaker. It watches one-cycle intrinsic pulse strobes from the upper (atrial) and lower (ventricular) heart chambers. It turns the ones that fall outside refractory windows into sense strobes. When the heart stays silent for too long, it issues atrial and ventricular pace strobes itself. All timing is counted in ticks of an external strobe, nominally one per millisecond.

Two saturating counters carry all the intervals. One holds the ticks since the last ventricular event, which is a sense or a pace. It provides the atrial escape interval, both refractory windows, the upper rate limit and, indirectly, the lower rate limit. The other holds the ticks since the last atrial event and provides the AV delay. A one-bit phase register records whether the controller is waiting for an atrial event or for a ventricular event.

Every decision takes "elapsed ticks" to mean the stored count plus the tick arriving in the same cycle. A pace therefore comes out in the cycle right after the tick that completes its interval. With the default values this keeps ventricular-to-ventricular spacing within AEI + AVD.

Top module: `dual_chamber_pacer`

## Requirements
- R1: While rst is high, and in the cycle after it is sampled high, all four output strobes are low. After reset the controller waits for an atrial event and both counters hold zero, so the controller behaves as if a ventricular event had just occurred. With no intrinsic pulses, the first atrial pace appears AEI ticks after reset is released.
- R2: In the atrial-wait phase, if no atrial sense occurs, a_pace is issued in the cycle after the tick that brings the ticks since the last ventricular event to AEI.
- R3: After an atrial sense or pace, and with no ventricular sense, v_pace is issued once AVD ticks have elapsed since that atrial event, provided R4 allows it.
- R4: v_pace is never issued before URI ticks have elapsed since the last ventricular event. When the AV delay ends earlier than that, the pace is deferred to the tick on which URI is reached.
- R5: A v_pulse arriving while fewer than VRP ticks have elapsed since the last ventricular event (counting a tick in the same cycle) produces no v_sense and does not change any later pacing time.
- R6: An a_pulse arriving while fewer than PVARP ticks have elapsed since the last ventricular event produces no a_sense and does not change any later pacing time.
- R7: A v_pulse outside the ventricular refractory window produces v_sense one cycle later. It cancels any pending ventricular pace and restarts the ventricular-based timing, so the next atrial pace comes AEI ticks after that sense.
- R8: Counters advance only on cycles with tick high. With tick held low, no pace strobe is ever produced, and timing resumes from where it stopped.
- R9: Each output strobe is high for exactly one cycle, and at most one of the four strobes is high in any cycle.
- R10: With no intrinsic activity, consecutive ventricular events are exactly AEI + AVD ticks apart, and no two are ever further apart than that.
- R11: An a_pulse arriving while the controller waits for a ventricular event is ignored. It produces no a_sense and does not restart the AV delay.
- R12: When a qualifying intrinsic pulse arrives in the same cycle that a pace of that chamber would be issued, the sense wins and the pace is not issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe, one pulse per timing unit |
| a_pulse | input | 1 | One-cycle intrinsic atrial pulse from the heart |
| v_pulse | input | 1 | One-cycle intrinsic ventricular pulse from the heart |
| a_pace | output | 1 | One-cycle atrial pace strobe |
| v_pace | output | 1 | One-cycle ventricular pace strobe |
| a_sense | output | 1 | One-cycle atrial sense strobe |
| v_sense | output | 1 | One-cycle ventricular sense strobe |

## Verification
The assertions run on every cycle and check the following:
- a pace happens only on a tick;
- an atrial pace lands exactly on the escape count;
- no ventricular pace comes ahead of either the AV delay or the upper rate limit;
- no sense is issued inside its refractory window;
- the ventricular spacing stays within the lower rate limit;
- the strobes stay one cycle wide and mutually exclusive.

The refractory and upper-rate checks run against an independent tick count kept from the output strobes. Only the bench scenarios show that a dropped pulse really leaves later pacing times unchanged. The same holds for the exact deferred pace time across the sweep of atrial sense offsets, a ventricular sense cancelling a pending pace, the ties between sense and pace, and atrial pulses being ignored while the controller waits for a ventricular event.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  typedef enum logic {
    PH_AWAIT = 1'b0,
    PH_VWAIT = 1'b1
  } phase_t;

  // Ticks elapsed at decision time: stored count plus a tick arriving now.
  function automatic int unsigned elapsed_f(int unsigned cnt, logic tick);
    return cnt + {31'b0, tick};
  endfunction

  // True once an interval of lim ticks has been completed.
  function automatic logic reached_f(int unsigned el, int unsigned lim);
    return el >= lim;
  endfunction

  // Counter width able to hold span plus headroom before saturation.
  function automatic int unsigned cnt_width_f(int unsigned span);
    return $clog2(span + 2);
  endfunction

endpackage

// File: rtl/pacer_tick_counter.sv
module pacer_tick_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick && (cnt != TOP)) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/pacer_decide.sv
module pacer_decide
  import pacer_pkg::*;
#(
  parameter int unsigned AVD   = 150,
  parameter int unsigned AEI   = 800,
  parameter int unsigned VRP   = 150,
  parameter int unsigned PVARP = 100,
  parameter int unsigned URI   = 400
) (
  input  phase_t      phase,
  input  logic        a_pulse,
  input  logic        v_pulse,
  input  int unsigned v_el,
  input  int unsigned a_el,
  output logic        a_sense_e,
  output logic        a_pace_e,
  output logic        v_sense_e,
  output logic        v_pace_e
);
  logic v_window_open;
  logic a_window_open;
  logic v_ok;
  logic a_ok;
  logic av_done;
  logic upper_done;
  logic escape_done;

  always_comb begin
    v_window_open = reached_f(v_el, VRP);
    a_window_open = reached_f(v_el, PVARP);
    av_done       = reached_f(a_el, AVD);
    upper_done    = reached_f(v_el, URI);
    escape_done   = reached_f(v_el, AEI);

    v_ok = v_pulse && v_window_open;
    a_ok = a_pulse && a_window_open && (phase == PH_AWAIT);

    // A ventricular sense outranks everything; an atrial sense outranks the atrial pace.
    v_sense_e = v_ok;
    v_pace_e  = !v_ok && (phase == PH_VWAIT) && av_done && upper_done;
    a_sense_e = !v_ok && a_ok;
    a_pace_e  = !v_ok && !a_ok && (phase == PH_AWAIT) && escape_done;
  end
endmodule

// File: rtl/dual_chamber_pacer.sv
module dual_chamber_pacer
  import pacer_pkg::*;
#(
  parameter int unsigned AVD   = 150,
  parameter int unsigned AEI   = 800,
  parameter int unsigned VRP   = 150,
  parameter int unsigned PVARP = 100,
  parameter int unsigned URI   = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic a_pulse,
  input  logic v_pulse,
  output logic a_pace,
  output logic v_pace,
  output logic a_sense,
  output logic v_sense
);
  localparam int unsigned CW    = cnt_width_f(AEI + AVD + URI);
  localparam int unsigned NCH   = 2;
  localparam int unsigned IDX_V = 0;
  localparam int unsigned IDX_A = 1;

  phase_t          phase_q;
  phase_t          phase_d;
  logic [CW-1:0]   cnt_q [NCH];
  logic [NCH-1:0]  clr_vec;
  int unsigned     v_el;
  int unsigned     a_el;

  // Named internal events.
  logic evt_as;
  logic evt_ap;
  logic evt_vs;
  logic evt_vp;
  logic evt_v;
  logic evt_a;

  for (genvar g = 0; g < NCH; g++) begin : g_cnt
    pacer_tick_counter #(.W(CW)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .clr  (clr_vec[g]),
      .cnt  (cnt_q[g])
    );
  end

  assign v_el = elapsed_f(32'(cnt_q[IDX_V]), tick);
  assign a_el = elapsed_f(32'(cnt_q[IDX_A]), tick);

  pacer_decide #(
    .AVD(AVD), .AEI(AEI), .VRP(VRP), .PVARP(PVARP), .URI(URI)
  ) u_dec (
    .phase     (phase_q),
    .a_pulse   (a_pulse),
    .v_pulse   (v_pulse),
    .v_el      (v_el),
    .a_el      (a_el),
    .a_sense_e (evt_as),
    .a_pace_e  (evt_ap),
    .v_sense_e (evt_vs),
    .v_pace_e  (evt_vp)
  );

  assign evt_v = evt_vs | evt_vp;
  assign evt_a = evt_as | evt_ap;

  always_comb begin
    clr_vec        = '0;
    clr_vec[IDX_V] = evt_v;
    clr_vec[IDX_A] = evt_a;
  end

  always_comb begin
    phase_d = phase_q;
    if (evt_v) begin
      phase_d = PH_AWAIT;
    end else if (evt_a) begin
      phase_d = PH_VWAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_AWAIT;
      a_pace  <= 1'b0;
      v_pace  <= 1'b0;
      a_sense <= 1'b0;
      v_sense <= 1'b0;
    end else begin
      phase_q <= phase_d;
      a_pace  <= evt_ap;
      v_pace  <= evt_vp;
      a_sense <= evt_as;
      v_sense <= evt_vs;
    end
  end
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker #(
  parameter int unsigned AVD   = 150,
  parameter int unsigned AEI   = 800,
  parameter int unsigned VRP   = 150,
  parameter int unsigned PVARP = 100,
  parameter int unsigned URI   = 400
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic a_pace,
  input logic v_pace,
  input logic a_sense,
  input logic v_sense
);
  // Tick counts rebuilt from the output strobes alone.
  int unsigned since_v;
  int unsigned since_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_v <= 0;
      since_a <= 0;
    end else begin
      since_v <= (v_pace || v_sense) ? {31'b0, tick} : since_v + {31'b0, tick};
      since_a <= (a_pace || a_sense) ? {31'b0, tick} : since_a + {31'b0, tick};
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !(a_pace || v_pace || a_sense || v_sense)); // R1

  AST_AP_ON_ESCAPE: assert property (@(posedge clk) disable iff (rst)
    a_pace |-> (since_v == AEI)); // R2

  AST_VP_AFTER_AVD: assert property (@(posedge clk) disable iff (rst)
    v_pace |-> (since_a >= AVD)); // R3

  AST_VP_AFTER_URI: assert property (@(posedge clk) disable iff (rst)
    v_pace |-> (since_v >= URI)); // R4

  AST_VS_OUTSIDE_VRP: assert property (@(posedge clk) disable iff (rst)
    v_sense |-> (since_v >= VRP)); // R5

  AST_AS_OUTSIDE_PVARP: assert property (@(posedge clk) disable iff (rst)
    a_sense |-> (since_v >= PVARP)); // R6

  AST_PACE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (a_pace || v_pace) |-> $past(tick)); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_pace, v_pace, a_sense, v_sense})); // R9

  AST_A_STROBE_SHORT: assert property (@(posedge clk) disable iff (rst)
    (a_pace || a_sense) |=> !(a_pace || a_sense)); // R9

  AST_V_STROBE_SHORT: assert property (@(posedge clk) disable iff (rst)
    (v_pace || v_sense) |=> !(v_pace || v_sense)); // R9

  AST_LOWER_RATE: assert property (@(posedge clk) disable iff (rst)
    (v_pace || v_sense) |-> (since_v <= AEI + AVD)); // R10
endmodule

bind dual_chamber_pacer pacer_checker #(
  .AVD(AVD), .AEI(AEI), .VRP(VRP), .PVARP(PVARP), .URI(URI)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .a_pace  (a_pace),
  .v_pace  (v_pace),
  .a_sense (a_sense),
  .v_sense (v_sense)
);

// File: tb/dual_chamber_pacer_test.sv
module dual_chamber_pacer_test;
  localparam int PERIOD = 10;
  localparam int AVD   = 5;
  localparam int AEI   = 20;
  localparam int VRP   = 6;
  localparam int PVARP = 4;
  localparam int URI   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic a_pulse = 1'b0;
  logic v_pulse = 1'b0;
  logic a_pace, v_pace, a_sense, v_sense;

  dual_chamber_pacer #(
    .AVD(AVD), .AEI(AEI), .VRP(VRP), .PVARP(PVARP), .URI(URI)
  ) uut (
    .clk(clk), .rst(rst), .tick(tick), .a_pulse(a_pulse), .v_pulse(v_pulse),
    .a_pace(a_pace), .v_pace(v_pace), .a_sense(a_sense), .v_sense(v_sense)
  );

  always #(PERIOD / 2) clk = ~clk;

  int cyc = 0;
  int t_ap = -1000, t_vp = -1000, t_as = -1000, t_vs = -1000;
  int wide = 0, multi = 0, pace_cnt = 0;
  logic p_ap = 0, p_vp = 0, p_as = 0, p_vs = 0;
  int checks = 0, failures = 0;
  int base = 0;
  bit done = 0;

  always @(negedge clk) begin
    cyc++;
    if (a_pace) begin t_ap = cyc; pace_cnt++; end
    if (v_pace) begin t_vp = cyc; pace_cnt++; end
    if (a_sense) t_as = cyc;
    if (v_sense) t_vs = cyc;
    if (!rst) begin
      if ((a_pace && p_ap) || (v_pace && p_vp) || (a_sense && p_as) || (v_sense && p_vs)) wide++;
      if ($countones({a_pace, v_pace, a_sense, v_sense}) > 1) multi++;
    end
    p_ap = a_pace; p_vp = v_pace; p_as = a_sense; p_vs = v_sense;
  end

  task automatic chk_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic run(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic sync_v();
    while (t_vp != cyc && t_vs != cyc) step();
    base = cyc;
  endtask

  task automatic pulse_a(int n);
    run(n);
    a_pulse = 1'b1;
    step();
    a_pulse = 1'b0;
  endtask

  task automatic pulse_v(int n);
    run(n);
    v_pulse = 1'b1;
    step();
    v_pulse = 1'b0;
  endtask

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a_mark;
    // R1: quiet during reset, then free-running pacing from reset release.
    run(3);
    chk_eq("R1 strobes in reset", int'({a_pace, v_pace, a_sense, v_sense}), 0);
    rst = 1'b0;
    base = cyc;
    run(AEI);
    chk_eq("R1 first a_pace after reset", t_ap, base + AEI);
    chk_eq("R1 no strobe before first pace", t_vp, -1000);
    run(AVD);
    chk_eq("R3 v_pace after paced atrium", t_vp, base + AEI + AVD);
    sync_v();
    run(AEI);
    chk_eq("R2 escape pace", t_ap, base + AEI);
    run(AVD);
    chk_eq("R10 paced V-V spacing", t_vp - base, AEI + AVD);

    // R6, R4, R3: sweep atrial pulse offset after a ventricular event.
    for (int n = 0; n < AEI; n++) begin
      sync_v();
      pulse_a(n);
      if (n + 1 >= PVARP) begin
        int j;
        chk_eq((n + 1 == AEI) ? "R12 atrial sense beats pace" : "R6 atrial sensed",
               t_as, cyc);
        a_mark = cyc;
        j = maxi(AVD, URI - (n + 1));
        run(j);
        chk_eq((j > AVD) ? "R4 deferred v_pace" : "R3 AV delay v_pace", t_vp, a_mark + j);
      end else begin
        run(base + AEI - cyc);
        chk_eq("R6 refractory atrial ignored", t_as < base ? 1 : 0, 1);
        chk_eq("R6 pace unchanged", t_ap, base + AEI);
        run(AVD);
        chk_eq("R3 v_pace after pace", t_vp, base + AEI + AVD);
      end
    end

    // R5, R7: sweep ventricular pulse offset in the atrial-wait phase.
    for (int n = 0; n < VRP + 3; n++) begin
      sync_v();
      pulse_v(n);
      if (n + 1 >= VRP) begin
        chk_eq("R7 ventricular sensed", t_vs, cyc);
        a_mark = cyc;
        run(AEI);
        chk_eq("R7 escape restarted by sense", t_ap, a_mark + AEI);
      end else begin
        chk_eq("R5 refractory ventricular ignored", t_vs < base ? 1 : 0, 1);
        run(base + AEI - cyc);
        chk_eq("R5 pace unchanged", t_ap, base + AEI);
      end
    end

    // R7, R12: ventricular pulse during the AV delay, sensed at 13 ticks.
    for (int m = 0; m < AVD + 3; m++) begin
      sync_v();
      pulse_a(12);
      a_mark = cyc;
      pulse_v(m);
      if (m + 1 <= AVD) begin
        chk_eq((m + 1 == AVD) ? "R12 ventricular sense beats pace" : "R7 sense in AV delay",
               t_vs, a_mark + m + 1);
        run(AEI);
        chk_eq("R7 pending pace cancelled", t_vp < a_mark ? 1 : 0, 1);
        chk_eq("R7 escape from sense", t_ap, a_mark + m + 1 + AEI);
      end else begin
        chk_eq("R3 pace at AV delay", t_vp, a_mark + AVD);
        chk_eq("R5 post-pace pulse ignored", t_vs < a_mark ? 1 : 0, 1);
      end
    end

    // R11: atrial pulse while waiting for the ventricle.
    sync_v();
    pulse_a(12);
    a_mark = cyc;
    pulse_a(2);
    chk_eq("R11 no second atrial sense", t_as, a_mark);
    run(a_mark + AVD - cyc);
    chk_eq("R11 AV delay not restarted", t_vp, a_mark + AVD);

    // R8: tick held low freezes all timing.
    sync_v();
    begin
      int pc;
      pc = pace_cnt;
      tick = 1'b0;
      run(50);
      chk_eq("R8 no pace without tick", pace_cnt, pc);
      tick = 1'b1;
      run(AEI);
      chk_eq("R8 escape resumes", t_ap, base + 50 + AEI);
    end

    chk_eq("R9 strobe width", wide, 0);
    chk_eq("R9 one strobe per cycle", multi, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule